// File: doc/BRIEF.md
# Paged monochrome LCD controller

This block drives the picture memory of a 128 by 64 monochrome panel. The host writes three word-wide registers. A mode word decides whether bytes that arrive at the data port are panel commands or pixel bytes. An instruction port accepts page-select commands at any time. Video memory is arranged as eight pages of 128 columns. Each byte holds eight vertically stacked pixels, and a write cursor (page, column) steps across a page as pixel bytes arrive.

A display-side scan port reads one pixel by x and y coordinate. A shading stage turns that pixel into a 24-bit RGB value. A set pixel takes the foreground colour 0xE0E0FF, dimmed to one of eight brightness levels. The level is decoded from a GPIO control word. A clear pixel is black.

The mode register is a three-state machine with states MODE_OFF (no valid mode), MODE_DATA and MODE_CMD. Each write to the mode register takes one of three transitions from any state: DATA_SEL enters MODE_DATA, CMD_SEL enters MODE_CMD, and DROP enters MODE_OFF for any other value. With no mode write, the machine holds its state.

Top module: `lcd_page_ctrl`

## Requirements
- R1: After reset, the mode is MODE_OFF, the cursor is at page 0 column 0, and the colour output is 0x000000. The first data byte written after the host enters data mode lands at page 0 column 0.
- R2: A write to offset 0x1AC selects the mode. 0x00100011 selects data mode. 0x00104011 selects command mode. Any other value, including near misses such as 0x00100010, selects MODE_OFF.
- R3: A write to offset 0x1BC whose full 32-bit value lies in 0xB0..0xB7 selects page (value − 0xB0) and sets the column to 0, in every mode. Any other value written there changes nothing.
- R4: In command mode, a write to offset 0x1C0 behaves as in R3. A value outside 0xB0..0xB7 is ignored, and neither the memory nor the cursor changes.
- R5: In data mode, a write to offset 0x1C0 stores bits 7:0 at byte address page*128 + column, and the column then advances by one.
- R6: When the column is 127, a stored byte returns the column to 0 and leaves the page unchanged.
- R7: In MODE_OFF, a write to offset 0x1C0 stores nothing and returns the cursor to page 0 column 0.
- R8: Pixel (x, y) is bit (y mod 8) of byte x + (y/8)*128. The pixel addressed by scan_x/scan_y at a clock edge appears after that edge.
- R9: A set pixel outputs each channel of 0xE0E0FF scaled to floor(channel*L/7), where L is the brightness level. A clear pixel outputs 0x000000. The colour follows bright_code without a clock.
- R10: The brightness codes map as follows: 0x00000007→0, 0x00020000→1, 0x00020001→2, 0x00040000→3, 0x00010006→4, 0x00020005→5, 0x00040003→6, 0x00030004→7. Any other code gives level 7.
- R11: Writes to any other offset, such as the interrupt-control offset 0x180, change neither the mode, the cursor nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write value |
| bright_code | input | 32 | GPIO brightness control word |
| scan_x | input | 7 | Scan column 0..127 |
| scan_y | input | 6 | Scan row 0..63 |
| pix_rgb | output | 24 | Scanned pixel colour, RRGGBB |

## Verification
On every cycle, the assertions check four things: that a rejected mode word drops the machine to MODE_OFF, that a page select zeroes the column and loads the page, that the column wraps at 127 within the same page, and that an off-mode data write clears the cursor. They also check that a set pixel at full brightness shows the exact foreground colour. The actual contents of the video memory, the x/y-to-bit mapping, and the eight brightness scalings are visible only through the bench's scenarios. In those scenarios, every one of the 8192 pixels is read back against a model that is updated from the requirements.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DATA = 2'd1,
        MODE_CMD  = 2'd2
    } lcd_mode_e;

    localparam logic [11:0] OFS_MODE  = 12'h1AC;
    localparam logic [11:0] OFS_INSTR = 12'h1BC;
    localparam logic [11:0] OFS_DATA  = 12'h1C0;

    localparam logic [31:0] WORD_DATA = 32'h0010_0011;
    localparam logic [31:0] WORD_CMD  = 32'h0010_4011;
    localparam logic [31:0] OP_PAGE0  = 32'h0000_00B0;

    function automatic logic [2:0] level_of(input logic [31:0] code);
        logic [2:0] lvl;
        case (code)
            32'h0000_0007: lvl = 3'd0;
            32'h0002_0000: lvl = 3'd1;
            32'h0002_0001: lvl = 3'd2;
            32'h0004_0000: lvl = 3'd3;
            32'h0001_0006: lvl = 3'd4;
            32'h0002_0005: lvl = 3'd5;
            32'h0004_0003: lvl = 3'd6;
            default:       lvl = 3'd7;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/lcd_mode_fsm.sv
module lcd_mode_fsm
    import lcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [31:0] wr_data,
    output lcd_mode_e   mode
);

    lcd_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_OFF;
        else        state_q <= state_d;
    end

    // transitions: DATA_SEL, CMD_SEL, DROP (any state), hold otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OFF, MODE_DATA, MODE_CMD: begin
                if (mode_wr) begin
                    if (wr_data == WORD_DATA)     state_d = MODE_DATA;
                    else if (wr_data == WORD_CMD) state_d = MODE_CMD;
                    else                          state_d = MODE_OFF;
                end
            end
            default: state_d = MODE_OFF;
        endcase
    end

    // outputs
    always_comb mode = state_q;

    a_r2_bad_word_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wr_data != WORD_DATA && wr_data != WORD_CMD) |=> (mode == MODE_OFF));

endmodule

// File: rtl/lcd_cursor.sv
module lcd_cursor
    import lcd_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int PAGES = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int VA_W   = COL_W + PAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lcd_mode_e        mode,
    input  logic             instr_wr,
    input  logic             data_wr,
    input  logic [31:0]      wr_data,
    output logic             st_en,
    output logic [VA_W-1:0]  st_addr,
    output logic [7:0]       st_byte
);

    logic [PAGE_W-1:0] page_q, page_d;
    logic [COL_W-1:0]  col_q, col_d;
    logic              is_sel;
    logic [31:0]       sel_off;

    always_comb begin
        sel_off = wr_data - OP_PAGE0;
        is_sel  = (wr_data >= OP_PAGE0) && (sel_off < 32'(PAGES));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            col_q  <= '0;
        end else begin
            page_q <= page_d;
            col_q  <= col_d;
        end
    end

    always_comb begin
        page_d = page_q;
        col_d  = col_q;
        st_en  = 1'b0;
        if (instr_wr) begin
            if (is_sel) begin
                page_d = sel_off[PAGE_W-1:0];
                col_d  = '0;
            end
        end else if (data_wr) begin
            unique case (mode)
                MODE_CMD: begin
                    if (is_sel) begin
                        page_d = sel_off[PAGE_W-1:0];
                        col_d  = '0;
                    end
                end
                MODE_DATA: begin
                    st_en = 1'b1;
                    col_d = (col_q == COL_W'(COLS - 1)) ? '0 : col_q + 1'b1;
                end
                default: begin
                    page_d = '0;
                    col_d  = '0;
                end
            endcase
        end
    end

    always_comb begin
        st_addr = {page_q, col_q};
        st_byte = wr_data[7:0];
    end

    a_r3_select_zeroes_col: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_wr && is_sel) |=> (col_q == '0 && page_q == $past(wr_data[PAGE_W-1:0])));

    a_r6_col_wraps_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && col_q == COL_W'(COLS - 1)) |=> (col_q == '0 && $stable(page_q)));

    a_r7_off_write_homes: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && mode == MODE_OFF) |=> (page_q == '0 && col_q == '0));

endmodule

// File: rtl/lcd_vram.sv
module lcd_vram #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    input  logic [2:0]    rbit,
    output logic          pix
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix <= 1'b0;
        else        pix <= mem[raddr][rbit];
    end

endmodule

// File: rtl/lcd_shade.sv
module lcd_shade
    import lcd_pkg::*;
#(
    parameter logic [23:0] FG_RGB = 24'hE0E0FF
) (
    input  logic        pix_on,
    input  logic [31:0] bright_code,
    output logic [23:0] rgb
);

    logic [2:0] level;
    always_comb level = level_of(bright_code);

    for (genvar i = 0; i < 3; i++) begin : g_chan
        localparam logic [7:0] CH = FG_RGB[8*i +: 8];
        logic [10:0] prod;
        logic [10:0] quot;
        always_comb begin
            prod = 11'(CH) * 11'(level);
            quot = prod / 11'd7;
            rgb[8*i +: 8] = pix_on ? quot[7:0] : 8'h00;
        end
    end

endmodule

// File: rtl/lcd_page_ctrl.sv
module lcd_page_ctrl
    import lcd_pkg::*;
#(
    parameter int          COLS   = 128,
    parameter int          PAGES  = 8,
    parameter logic [23:0] FG_RGB = 24'hE0E0FF,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(PAGES) + 3,
    localparam int DEPTH = COLS * PAGES,
    localparam int VA_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [11:0]      wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      bright_code,
    input  logic [COL_W-1:0] scan_x,
    input  logic [ROW_W-1:0] scan_y,
    output logic [23:0]      pix_rgb
);

    logic            mode_wr, instr_wr, data_wr;
    lcd_mode_e       mode;
    logic            st_en;
    logic [VA_W-1:0] st_addr;
    logic [7:0]      st_byte;
    logic            pix_on;

    always_comb begin
        mode_wr  = wr_en && (wr_addr == OFS_MODE);
        instr_wr = wr_en && (wr_addr == OFS_INSTR);
        data_wr  = wr_en && (wr_addr == OFS_DATA);
    end

    lcd_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .wr_data (wr_data),
        .mode    (mode)
    );

    lcd_cursor #(.COLS(COLS), .PAGES(PAGES)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .instr_wr (instr_wr),
        .data_wr  (data_wr),
        .wr_data  (wr_data),
        .st_en    (st_en),
        .st_addr  (st_addr),
        .st_byte  (st_byte)
    );

    lcd_vram #(.DEPTH(DEPTH)) u_vram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_en),
        .waddr (st_addr),
        .wdata (st_byte),
        .raddr ({scan_y[ROW_W-1:3], scan_x}),
        .rbit  (scan_y[2:0]),
        .pix   (pix_on)
    );

    lcd_shade #(.FG_RGB(FG_RGB)) u_shade (
        .pix_on      (pix_on),
        .bright_code (bright_code),
        .rgb         (pix_rgb)
    );

    a_r9_full_level_is_fg: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_on && bright_code == 32'h0003_0004) |-> (pix_rgb == FG_RGB));

endmodule

// File: tb/tb_lcd_page_ctrl.sv
`timescale 1ns/1ps
module tb_lcd_page_ctrl;

    localparam logic [31:0] M_DATA = 32'h0010_0011;
    localparam logic [31:0] M_CMD  = 32'h0010_4011;
    localparam logic [23:0] FG     = 24'hE0E0FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] bright_code = 32'h0003_0004;
    logic [6:0]  scan_x = '0;
    logic [5:0]  scan_y = '0;
    logic [23:0] pix_rgb;

    int vectors = 0;
    int fails = 0;

    // model state, maintained from the requirements
    int mmode = 0;
    int mp = 0;
    int mc = 0;
    logic [7:0] model [1024];

    logic [31:0] codes [8] = '{32'h0000_0007, 32'h0002_0000, 32'h0002_0001, 32'h0004_0000,
                               32'h0001_0006, 32'h0002_0005, 32'h0004_0003, 32'h0003_0004};

    always #5 clk = ~clk;

    lcd_page_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bright_code(bright_code), .scan_x(scan_x), .scan_y(scan_y), .pix_rgb(pix_rgb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit in_sel(input logic [31:0] v);
        return (v >= 32'hB0) && (v <= 32'hB7);
    endfunction

    task automatic set_mode(input logic [31:0] v);
        bus_write(12'h1AC, v);
        mmode = (v == M_DATA) ? 1 : (v == M_CMD) ? 2 : 0;
    endtask

    task automatic instr(input logic [31:0] v);
        bus_write(12'h1BC, v);
        if (in_sel(v)) begin mp = int'(v) - 'hB0; mc = 0; end
    endtask

    task automatic dwr(input logic [31:0] v);
        bus_write(12'h1C0, v);
        if (mmode == 2) begin
            if (in_sel(v)) begin mp = int'(v) - 'hB0; mc = 0; end
        end else if (mmode == 1) begin
            model[mp*128 + mc] = v[7:0];
            mc = (mc + 1) % 128;
        end else begin
            mp = 0; mc = 0;
        end
    endtask

    task automatic scan(input int x, input int y);
        @(negedge clk);
        scan_x = 7'(x); scan_y = 6'(y);
        @(posedge clk);
        #1;
    endtask

    task automatic read_byte(input int p, input int c, output logic [7:0] b);
        bright_code = 32'h0003_0004;
        for (int y = 0; y < 8; y++) begin
            scan(c, p*8 + y);
            b[y] = (pix_rgb != 24'h0);
        end
    endtask

    task automatic chk_byte(input string tag, input int p, input int c, input logic [7:0] exp);
        logic [7:0] b;
        read_byte(p, c, b);
        chk(tag, {24'h0, b}, {24'h0, exp});
    endtask

    function automatic logic [7:0] pat(input int p, input int c);
        return 8'((p*37 + c*11 + 5) & 255);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 colour after reset", {8'h0, pix_rgb}, 32'h0);

        // R1: cursor starts at page 0 column 0
        set_mode(M_DATA);
        dwr(32'h3C);
        chk_byte("R1 first byte at origin", 0, 0, 8'h3C);

        // R3/R4/R5: fill all pages, selecting via both ports
        for (int p = 0; p < 8; p++) begin
            if (p % 2 == 0) begin
                instr(32'hB0 + 32'(p));
            end else begin
                set_mode(M_CMD);
                dwr(32'hB0 + 32'(p));
                set_mode(M_DATA);
            end
            for (int c = 0; c < 128; c++) dwr({24'hABCDEF, pat(p, c)});
        end
        chk_byte("R3 even page via instruction", 4, 17, pat(4, 17));
        chk_byte("R4 odd page via data port", 7, 127, pat(7, 127));
        chk_byte("R5 stored byte", 2, 64, pat(2, 64));

        // R6: wrap within page 3
        instr(32'hB3);
        for (int c = 0; c < 128; c++) dwr(32'h11);
        dwr(32'h22); dwr(32'h33);
        chk_byte("R6 wrap col0", 3, 0, 8'h22);
        chk_byte("R6 wrap col1", 3, 1, 8'h33);
        chk_byte("R6 wrap col2", 3, 2, 8'h11);
        chk_byte("R6 next page untouched", 4, 0, pat(4, 0));

        // R3: reselect resets column
        instr(32'hB5);
        dwr(32'h41); dwr(32'h42); dwr(32'h43);
        instr(32'hB5);
        dwr(32'h7E);
        chk_byte("R3 reselect col0", 5, 0, 8'h7E);
        chk_byte("R3 reselect col1", 5, 1, 8'h42);

        // R2/R7: near-miss mode word is invalid; data write ignored and homes cursor
        set_mode(32'h0010_0010);
        dwr(32'h5A);
        chk_byte("R7 ignored write", 5, 1, 8'h42);
        set_mode(M_DATA);
        dwr(32'h81);
        chk_byte("R7 homed to origin", 0, 0, 8'h81);
        chk_byte("R2 invalid word left memory", 5, 2, 8'h43);

        // R4: non-select in command mode ignored; R3/R11: other values and offsets ignored
        instr(32'hB6);
        dwr(32'h0F);
        set_mode(M_CMD);
        dwr(32'h40);
        dwr(32'hB8);
        set_mode(M_DATA);
        dwr(32'hF0);
        chk_byte("R4 cmd non-select ignored", 6, 1, 8'hF0);
        chk_byte("R4 col0 kept", 6, 0, 8'h0F);
        instr(32'hB2);
        dwr(32'h99);
        bus_write(12'h180, 32'hB1);
        bus_write(12'h184, 32'h0010_4011);
        instr(32'h1B2);
        dwr(32'h66);
        chk_byte("R11 other offsets ignored", 2, 1, 8'h66);
        chk_byte("R3 wide value ignored", 2, 0, 8'h99);

        // R9/R10: brightness sweep on a set pixel (0,0) and a clear pixel (0,1)
        scan(0, 0);
        for (int l = 0; l < 8; l++) begin
            @(negedge clk); bright_code = codes[l]; #1;
            chk($sformatf("R10 level %0d", l), {8'h0, pix_rgb},
                {8'h0, 8'(224*l/7), 8'(224*l/7), 8'(255*l/7)});
        end
        @(negedge clk); bright_code = 32'h0000_0000; #1;
        chk("R10 unknown code full", {8'h0, pix_rgb}, {8'h0, FG});
        @(negedge clk); bright_code = 32'h0004_0000; #1;
        scan(0, 1);
        chk("R9 clear pixel black", {8'h0, pix_rgb}, 32'h0);

        // R8: full pixel sweep against the model
        @(negedge clk); bright_code = 32'h0003_0004;
        for (int y = 0; y < 64; y++) begin
            for (int x = 0; x < 128; x++) begin
                scan(x, y);
                chk($sformatf("R8 pixel %0d,%0d", x, y), {8'h0, pix_rgb},
                    {8'h0, (model[(y/8)*128 + x][y%8] ? FG : 24'h0)});
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule